// File: doc/BRIEF.md
# Wavefront Issue Sequencer for a Sixteen-Lane VLIW Datapath

This block runs one instruction for a group of 64 work-items that move in lockstep. The datapath is only 16 lanes wide, so the block covers the group in four passes, one per clock. In pass `k`, lane `i` works on item `16*k + i`. Each lane is a processing element with five issue slots. Every slot is a scalar integer add or multiply that reads two registers of the item and writes one. Divergent items do not get their own instruction stream. The mask captured with the instruction suppresses their results instead. Each item has a private file of eight 16-bit registers inside the block.

A producer offers an instruction word and a 64-bit active mask with a valid/ready handshake. Ready drops for the four passes and returns in the same cycle that a one-cycle done strobe marks completion. A host port loads and reads the per-item registers: one item/register address that both writes and reads, with a combinational read value. Host writes take effect only while no instruction is in flight.

Top module: `wf_issue_seq`

## Requirements
- R1: After synchronous reset, every register of every item reads 0, `instr_ready` is 1 and `done` is 0.
- R2: The instruction word holds five 11-bit slots, with slot `s` in bits `[11*s+10 : 11*s]`. Within a slot, bit 10 is the enable, bit 9 is the operation (0 = add, 1 = multiply, keeping the low 16 bits of the product), bits 8:6 are the destination register, bits 5:3 are source A and bits 2:0 are source B. For each active item, every enabled slot writes `A op B` to the destination.
- R3: `instr_ready` is 0 in each of the four cycles after the clock edge that accepts an instruction, and is 1 again in the fifth.
- R4: `done` is 1 for exactly one cycle, the fifth cycle after acceptance, and is 0 at all other times.
- R5: Bit `n` of the mask captured at acceptance enables item `n`. Items whose bit is 0 keep all their registers unchanged.
- R6: An all-zero mask changes no register but keeps the same ready and done timing as any other instruction.
- R7: A slot whose enable bit is 0 writes nothing, even for active items.
- R8: All slots of a bundle read their sources before any slot writes back. A slot never sees a result produced in the same bundle.
- R9: When two enabled slots name the same destination for an item, the higher-numbered slot's result is kept.
- R10: When `host_we` is 1 and no instruction is in flight, the clock edge writes `host_wdata` into register `host_reg` of item `host_item`. While an instruction is in flight, `host_we` has no effect. `host_rdata` always shows register `host_reg` of item `host_item`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_valid | input | 1 | An instruction is offered |
| instr_ready | output | 1 | The sequencer can accept an instruction |
| instr_word | input | 55 | Five slot fields, slot 0 in the low bits |
| instr_mask | input | 64 | Per-item active mask, bit n for item n |
| done | output | 1 | One-cycle completion strobe |
| host_we | input | 1 | Host register write enable |
| host_item | input | 6 | Host item address |
| host_reg | input | 3 | Host register address |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Register value at the host address |

## Verification
A wrong pass counter or a wrong lane-to-item mapping puts results into the wrong rows. A full scan of the register file through the host port shows this right after the instruction that caused it, because the scan is compared with a model that evaluates the instruction item by item. A broken mask or a broken slot enable shows up in the same scan as a change to a register that should have held its value. Errors in slot ordering show up as wrong values in the concrete read-before-write and same-destination cases. Timing faults in the handshake are seen within the five cycles of the affected instruction, because ready and done are sampled in every one of those cycles.

// File: rtl/wf_pkg.sv
package wf_pkg;
    localparam int ITEMS  = 64;
    localparam int LANES  = 16;
    localparam int SLOTS  = 5;
    localparam int NREG   = 8;
    localparam int DW     = 16;
    localparam int PASSES = ITEMS / LANES;
    localparam int PW     = (PASSES > 1) ? $clog2(PASSES) : 1;
    localparam int IW     = $clog2(ITEMS);
    localparam int RIW    = $clog2(NREG);

    typedef enum logic {
        OP_ADD = 1'b0,
        OP_MUL = 1'b1
    } op_e;

    // One issue slot; packed MSB first: enable, op, dst, src A, src B
    typedef struct packed {
        logic           en;
        op_e            op;
        logic [RIW-1:0] dst;
        logic [RIW-1:0] sa;
        logic [RIW-1:0] sb;
    } slot_t;

    localparam int SLOT_W = $bits(slot_t);
    localparam int WORD_W = SLOTS * SLOT_W;

    typedef slot_t [SLOTS-1:0] bundle_t;
    typedef logic [NREG-1:0][DW-1:0] row_t;

    typedef struct packed {
        logic           we;
        logic [RIW-1:0] dst;
        logic [DW-1:0]  data;
    } wr_t;

    typedef wr_t [SLOTS-1:0] lane_wr_t;

    function automatic logic [DW-1:0] slot_alu(op_e op, logic [DW-1:0] a, logic [DW-1:0] b);
        logic [DW-1:0] r;
        case (op)
            OP_MUL:  r = a * b;
            default: r = a + b;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/wf_pass_ctl.sv
module wf_pass_ctl
    import wf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    output logic              instr_ready,
    input  logic [WORD_W-1:0] instr_word,
    input  logic [ITEMS-1:0]  instr_mask,
    output logic              busy,
    output logic [PW-1:0]     pass,
    output bundle_t           bundle_q,
    output logic [ITEMS-1:0]  mask_q,
    output logic              done
);
    localparam logic [PW-1:0] LAST = PW'(PASSES - 1);

    logic accept;
    assign instr_ready = !busy;
    assign accept      = instr_valid && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            pass     <= '0;
            done     <= 1'b0;
            bundle_q <= '0;
            mask_q   <= '0;
        end else begin
            done <= 1'b0;
            if (accept) begin
                busy     <= 1'b1;
                pass     <= '0;
                bundle_q <= bundle_t'(instr_word);
                mask_q   <= instr_mask;
            end else if (busy) begin
                if (pass == LAST) begin
                    busy <= 1'b0;
                    pass <= '0;
                    done <= 1'b1;
                end else begin
                    pass <= pass + 1'b1;
                end
            end
        end
    end

    // R3: an accepted instruction takes ready down on the next cycle
    assert_ready_drop_R3: assert property (@(posedge clk) disable iff (rst)
        (instr_valid && instr_ready) |=> !instr_ready);

    // R4: done is a single-cycle pulse
    assert_done_pulse_R4: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R4: done only follows the final pass of an instruction in flight
    assert_done_after_last_R4: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(busy) && $past(pass) == LAST));
endmodule

// File: rtl/wf_lane.sv
module wf_lane
    import wf_pkg::*;
(
    input  row_t     row,
    input  bundle_t  bundle,
    input  logic     active,
    output lane_wr_t wr
);
    always_comb begin
        for (int s = 0; s < SLOTS; s++) begin
            wr[s].we   = active && bundle[s].en;
            wr[s].dst  = bundle[s].dst;
            wr[s].data = slot_alu(bundle[s].op, row[bundle[s].sa], row[bundle[s].sb]);
        end
    end
endmodule

// File: rtl/wf_regfile.sv
module wf_regfile
    import wf_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 busy,
    input  logic [PW-1:0]        pass,
    input  logic [ITEMS-1:0]     mask_q,
    input  lane_wr_t [LANES-1:0] lane_wr,
    output row_t [LANES-1:0]     lane_rows,
    input  logic                 host_we,
    input  logic [IW-1:0]        host_item,
    input  logic [RIW-1:0]       host_reg,
    input  logic [DW-1:0]        host_wdata,
    output logic [DW-1:0]        host_rdata
);
    row_t [ITEMS-1:0] mem;
    logic [IW-1:0]    base;

    assign base       = IW'(int'(pass) * LANES);
    assign host_rdata = mem[host_item][host_reg];

    always_comb begin
        for (int i = 0; i < LANES; i++) begin
            lane_rows[i] = mem[base + IW'(i)];
        end
    end

    // Later slots are written last, so the highest enabled slot wins
    always_ff @(posedge clk) begin
        if (rst) begin
            mem <= '0;
        end else if (busy) begin
            for (int i = 0; i < LANES; i++) begin
                for (int s = 0; s < SLOTS; s++) begin
                    if (lane_wr[i][s].we) begin
                        mem[base + IW'(i)][lane_wr[i][s].dst] <= lane_wr[i][s].data;
                    end
                end
            end
        end else if (host_we) begin
            mem[host_item][host_reg] <= host_wdata;
        end
    end

    // R6: a pass with no active item leaves the whole file untouched
    assert_zero_mask_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (busy && mask_q == '0) |=> $stable(mem));

    // R10: when idle and no host write is requested, nothing changes
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        (!busy && !host_we) |=> $stable(mem));
endmodule

// File: rtl/wf_issue_seq.sv
module wf_issue_seq
    import wf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              instr_valid,
    output logic              instr_ready,
    input  logic [WORD_W-1:0] instr_word,
    input  logic [ITEMS-1:0]  instr_mask,
    output logic              done,
    input  logic              host_we,
    input  logic [IW-1:0]     host_item,
    input  logic [RIW-1:0]    host_reg,
    input  logic [DW-1:0]     host_wdata,
    output logic [DW-1:0]     host_rdata
);
    logic                 busy;
    logic [PW-1:0]        pass;
    bundle_t              bundle_q;
    logic [ITEMS-1:0]     mask_q;
    row_t [LANES-1:0]     lane_rows;
    lane_wr_t [LANES-1:0] lane_wr;
    logic [IW-1:0]        base;

    assign base = IW'(int'(pass) * LANES);

    wf_pass_ctl u_ctl (
        .clk         (clk),
        .rst         (rst),
        .instr_valid (instr_valid),
        .instr_ready (instr_ready),
        .instr_word  (instr_word),
        .instr_mask  (instr_mask),
        .busy        (busy),
        .pass        (pass),
        .bundle_q    (bundle_q),
        .mask_q      (mask_q),
        .done        (done)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic active;
        assign active = mask_q[base + IW'(l)];
        wf_lane u_lane (
            .row    (lane_rows[l]),
            .bundle (bundle_q),
            .active (active),
            .wr     (lane_wr[l])
        );
    end

    wf_regfile u_rf (
        .clk        (clk),
        .rst        (rst),
        .busy       (busy),
        .pass       (pass),
        .mask_q     (mask_q),
        .lane_wr    (lane_wr),
        .lane_rows  (lane_rows),
        .host_we    (host_we),
        .host_item  (host_item),
        .host_reg   (host_reg),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata)
    );
endmodule

// File: tb/wf_issue_seq_test.sv
module wf_issue_seq_test;
    import wf_pkg::*;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              instr_valid = 1'b0;
    logic              instr_ready;
    logic [WORD_W-1:0] instr_word = '0;
    logic [ITEMS-1:0]  instr_mask = '0;
    logic              done;
    logic              host_we = 1'b0;
    logic [IW-1:0]     host_item = '0;
    logic [RIW-1:0]    host_reg = '0;
    logic [DW-1:0]     host_wdata = '0;
    logic [DW-1:0]     host_rdata;

    int  total = 0;
    int  bad = 0;
    bit  finished = 0;
    logic [15:0] model [64][8];

    always #10 clk = ~clk;

    wf_issue_seq uut (.*);

    // Stimulus table: five slot codes (en, op, dst, srcA, srcB) and a mask per entry
    localparam logic [10:0] TS [6][5] = '{
        '{11'b1_0_001_010_011, 11'b1_1_010_011_100, 11'b1_0_011_100_101, 11'b1_1_100_101_110, 11'b1_0_101_110_111},
        '{11'b1_1_000_000_001, 11'b0_0_111_111_111, 11'b1_0_110_000_000, 11'b0_1_001_001_001, 11'b1_1_111_110_101},
        '{11'b1_0_010_010_010, 11'b1_0_010_011_011, 11'b1_1_001_111_000, 11'b1_0_000_111_111, 11'b0_0_000_000_000},
        '{11'b1_1_111_111_111, 11'b1_1_110_110_110, 11'b1_0_101_101_101, 11'b1_0_100_100_100, 11'b1_1_011_011_011},
        '{11'b0_1_000_001_010, 11'b1_0_100_000_001, 11'b1_0_100_010_011, 11'b1_1_000_100_100, 11'b1_0_001_000_111},
        '{11'b1_0_011_011_001, 11'b1_1_001_011_010, 11'b1_0_111_001_011, 11'b0_0_010_010_010, 11'b1_1_110_111_000}
    };
    localparam logic [63:0] TM [6] = '{
        64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_FFFF_0000, 64'hA5A5_5A5A_0F0F_F0F0,
        64'h8000_0000_0000_0001, 64'h1234_5678_9ABC_DEF0, 64'hFFFF_0000_0000_FFFF
    };

    function automatic logic [WORD_W-1:0] pack5(logic [10:0] s0, logic [10:0] s1,
                                                logic [10:0] s2, logic [10:0] s3, logic [10:0] s4);
        return {s4, s3, s2, s1, s0};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic host_write(input int item, input int r, input logic [15:0] d);
        host_we = 1'b1; host_item = IW'(item); host_reg = RIW'(r); host_wdata = d;
        @(posedge clk); @(negedge clk);
        host_we = 1'b0;
        model[item][r] = d;
    endtask

    task automatic rd(input int item, input int r, output logic [15:0] v);
        host_item = IW'(item); host_reg = RIW'(r);
        #1 v = host_rdata;
    endtask

    task automatic compare_all(input string tag);
        int miss = 0;
        logic [15:0] v;
        logic [15:0] fa = '0;
        logic [15:0] fe = '0;
        for (int it = 0; it < 64; it++) begin
            for (int r = 0; r < 8; r++) begin
                rd(it, r, v);
                if (v !== model[it][r]) begin
                    if (miss == 0) begin fa = v; fe = model[it][r]; end
                    miss++;
                end
            end
        end
        total++;
        if (miss != 0) begin
            bad++;
            $display("FAIL %s register scan: %0d mismatches, first act=%0h exp=%0h", tag, miss, fa, fe);
        end
        @(negedge clk);
    endtask

    task automatic model_apply(input logic [WORD_W-1:0] w, input logic [63:0] m);
        logic [15:0] old [8];
        logic [10:0] sl;
        for (int it = 0; it < 64; it++) begin
            if (m[it]) begin
                for (int r = 0; r < 8; r++) old[r] = model[it][r];
                for (int s = 0; s < 5; s++) begin
                    sl = w[11*s +: 11];
                    if (sl[10]) begin
                        if (sl[9]) model[it][sl[8:6]] = old[sl[5:3]] * old[sl[2:0]];
                        else       model[it][sl[8:6]] = old[sl[5:3]] + old[sl[2:0]];
                    end
                end
            end
        end
    endtask

    // Called at a falling edge with the sequencer idle
    task automatic issue(input logic [WORD_W-1:0] w, input logic [63:0] m, input bit poke);
        chk("R3 ready before issue", instr_ready, 1);
        instr_word = w; instr_mask = m; instr_valid = 1'b1;
        @(posedge clk); @(negedge clk);
        instr_valid = 1'b0;
        for (int c = 0; c < 4; c++) begin
            chk("R3 ready low while in flight", instr_ready, 0);
            chk("R4 done low while in flight", done, 0);
            if (poke && c == 1) begin
                host_we = 1'b1; host_item = 6'd9; host_reg = 3'd7; host_wdata = 16'hBEEF;
            end
            if (poke && c == 2) host_we = 1'b0;
            @(negedge clk);
        end
        chk("R3 ready back after fourth pass", instr_ready, 1);
        chk("R4 done in fifth cycle", done, 1);
        @(negedge clk);
        chk("R4 done lasts one cycle", done, 0);
        model_apply(w, m);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [15:0] keep;
        for (int it = 0; it < 64; it++)
            for (int r = 0; r < 8; r++) model[it][r] = '0;
        void'($urandom(32'h5EED_0042));

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset state
        chk("R1 ready after reset", instr_ready, 1);
        chk("R1 done after reset", done, 0);
        compare_all("R1 zero registers");

        // R10: host loading of every register
        for (int it = 0; it < 64; it++)
            for (int r = 0; r < 8; r++) host_write(it, r, 16'($urandom));
        compare_all("R10 host load");

        // R2 and R5: table of bundles and partial masks
        for (int t = 0; t < 6; t++) begin
            issue(pack5(TS[t][0], TS[t][1], TS[t][2], TS[t][3], TS[t][4]), TM[t], 1'b0);
            compare_all("R2 R5 table entry");
        end

        // R6: all-zero mask with every slot enabled
        issue(pack5(TS[0][0], TS[0][1], TS[0][2], TS[0][3], TS[0][4]), 64'h0, 1'b0);
        compare_all("R6 zero mask");

        // R7: only slot 2 enabled, full mask
        issue(pack5(11'b0_0_001_010_011, 11'b0_1_010_011_100, 11'b1_0_111_000_001,
                    11'b0_0_011_011_011, 11'b0_1_100_100_100), '1, 1'b0);
        compare_all("R7 disabled slots");

        // R8: read before write inside a bundle, concrete on item 5
        host_write(5, 1, 16'd10); host_write(5, 2, 16'd20); host_write(5, 3, 16'd3);
        issue(pack5(11'b1_0_001_010_011, 11'b1_0_010_001_011, 11'b1_1_011_001_010,
                    11'b0_0_000_000_000, 11'b0_0_000_000_000), '1, 1'b0);
        rd(5, 1, v); chk("R8 slot0 result", v, 16'd23);
        rd(5, 2, v); chk("R8 slot1 used old r1", v, 16'd13);
        rd(5, 3, v); chk("R8 slot2 used old r1 r2", v, 16'd200);
        @(negedge clk);
        compare_all("R8 full scan");

        // R9: same destination in slots 1 and 3; slot 4 checks product truncation (R2)
        host_write(7, 1, 16'd6); host_write(7, 2, 16'd7);
        host_write(11, 5, 16'h1234); host_write(11, 6, 16'h0100);
        issue(pack5(11'b0_0_000_000_000, 11'b1_0_100_001_010, 11'b0_0_000_000_000,
                    11'b1_1_100_001_010, 11'b1_1_111_101_110), '1, 1'b0);
        rd(7, 4, v);  chk("R9 higher slot wins", v, 16'd42);
        rd(11, 7, v); chk("R2 product keeps low bits", v, 16'h3400);
        @(negedge clk);
        compare_all("R9 full scan");

        // R10: host write during an instruction is ignored
        rd(9, 7, keep);
        @(negedge clk);
        issue(pack5(11'b1_0_000_001_010, 11'b0_0_000_000_000, 11'b0_0_000_000_000,
                    11'b0_0_000_000_000, 11'b0_0_000_000_000), 64'h1, 1'b1);
        rd(9, 7, v); chk("R10 host write ignored while in flight", v, keep);
        @(negedge clk);
        compare_all("R10 full scan after ignored write");

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule